// File: doc/BRIEF.md
# Sequential Shift-Subtract Integer Divider

This block divides one unsigned WIDTH-bit integer by another and produces one quotient bit per clock. A single double-width working register carries the partial remainder in its upper part and gathers quotient bits in its lower part as the value shifts left, so no separate quotient register exists. The working register is shifted once when the operands are loaded. At the end, the upper part is shifted back right by one place to give the remainder.

Two iteration modes are offered. In the restoring mode a failed trial subtraction is thrown away. In the non-restoring mode a negative partial remainder is kept, and the next step adds the divisor instead of subtracting it. When such a run ends below zero, one closing add of the divisor fixes the remainder. Both modes give the same quotient and remainder. A zero divisor is caught when the operands are taken, and the block finishes at once with a flag set.

Top module: `seq_divider`

## Requirements
- R1: After reset, busy_o, done_o and div_by_zero_o are 0 and quotient_o and remainder_o are all zeros.
- R2: With mode_i = 0 (restoring) and a non-zero divisor, the completed run gives quotient_o = dividend / divisor and remainder_o = dividend % divisor, both unsigned.
- R3: With mode_i = 1 (non-restoring) the completed run gives the same quotient and remainder as R2. This includes runs whose last partial remainder is negative, which need the closing add.
- R4: A start taken while idle with a non-zero divisor sets busy_o on the next cycle. busy_o stays high for WIDTH cycles. done_o is high for exactly one cycle, in the cycle that busy_o falls, which is WIDTH cycles after the start edge.
- R5: A start with a zero divisor never raises busy_o. On the next cycle done_o pulses with div_by_zero_o = 1, quotient_o all ones and remainder_o equal to the dividend.
- R6: start_i, dividend_i, divisor_i and mode_i are ignored while busy_o is high. The running division completes on its own schedule with its original operands.
- R7: quotient_o and remainder_o keep their last values until the next run completes. div_by_zero_o stays set until a start with a non-zero divisor is taken, which clears it on the next cycle.
- R8: The edge operands give the exact results: a dividend smaller than the divisor, a divisor of 1, both operands at their maximum, and a dividend of 0.
- R9: A start presented in the cycle that done_o is high is taken as a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Take operands and begin when idle |
| mode_i | input | 1 | 0 restoring, 1 non-restoring |
| dividend_i | input | WIDTH | Unsigned dividend |
| divisor_i | input | WIDTH | Unsigned divisor |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_by_zero_o | output | 1 | Last taken start had a zero divisor |
| quotient_o | output | WIDTH | Quotient of the last completed run |
| remainder_o | output | WIDTH | Remainder of the last completed run |

## Verification
The completion pulse of one run can fall in the same cycle as the start of the next. The bench drives a new start with fresh operands during the done_o cycle. In the cycle after that edge it expects done_o low, busy_o high and the previous results still on the outputs. WIDTH cycles later it expects the new results. A second collision places a start in the middle of a run, and the bench judges it by the original results and by done_o arriving on the original schedule.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic {
    MODE_RESTORE    = 1'b0,
    MODE_NONRESTORE = 1'b1
  } div_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic zero_div_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic dbz_load_o,
  output logic busy_o,
  output logic done_o,
  output logic dbz_o
);
  import div_pkg::*;

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(WIDTH - 1);

  div_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic accept;

  assign accept     = (state_q == ST_IDLE) && start_i;
  assign load_o     = accept && !zero_div_i;
  assign dbz_load_o = accept && zero_div_i;
  assign step_o     = (state_q == ST_RUN);
  assign last_o     = step_o && (cnt_q == LAST_CNT);
  assign busy_o     = (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
      dbz_o   <= 1'b0;
    end else begin
      done_o <= last_o || dbz_load_o;
      if (accept) dbz_o <= zero_div_i;
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (load_o) state_q <= ST_RUN;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_o) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int WIDTH = 32
) (
  input  logic                  mode_i,
  input  logic signed [WIDTH+1:0] hi_i,
  input  logic [WIDTH-1:0]      lo_i,
  input  logic [WIDTH-1:0]      div_i,
  output logic signed [WIDTH+1:0] hi_o,
  output logic [WIDTH-1:0]      lo_o
);
  import div_pkg::*;

  localparam int HW = WIDTH + 2;

  logic signed [HW-1:0] d_ext, t_sub, t_add, keep;
  logic qbit;
  logic unused_top;

  assign d_ext = $signed({2'b00, div_i});
  assign t_sub = hi_i - d_ext;
  assign t_add = hi_i + d_ext;

  always_comb begin
    if (div_mode_e'(mode_i) == MODE_NONRESTORE) begin
      // negative partial remainder: add this step instead of subtracting
      keep = hi_i[HW-1] ? t_add : t_sub;
      qbit = ~keep[HW-1];
    end else begin
      qbit = ~t_sub[HW-1];
      keep = qbit ? t_sub : hi_i;
    end
  end

  // keep fits in HW-1 bits signed, so dropping its top bit is lossless
  assign unused_top = keep[HW-1];
  assign hi_o = $signed({keep[HW-2:0], lo_i[WIDTH-1]});
  assign lo_o = {lo_i[WIDTH-2:0], qbit};
endmodule

// File: rtl/div_fixup.sv
module div_fixup #(
  parameter int WIDTH = 32
) (
  input  logic                  mode_i,
  input  logic signed [WIDTH+1:0] hi_i,
  input  logic [WIDTH-1:0]      div_i,
  output logic [WIDTH-1:0]      rem_o
);
  import div_pkg::*;

  localparam int HW = WIDTH + 2;

  logic signed [HW-1:0] back, fixed;
  logic [1:0] unused_hi;

  // undo the extra left shift of the last step
  assign back = hi_i >>> 1;

  always_comb begin
    fixed = back;
    if (div_mode_e'(mode_i) == MODE_NONRESTORE && back[HW-1])
      fixed = back + $signed({2'b00, div_i});
  end

  assign unused_hi = fixed[HW-1:HW-2];
  assign rem_o = fixed[WIDTH-1:0];
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             div_by_zero_o,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o
);
  localparam int HW = WIDTH + 2;

  logic load, step, last, dbz_load;
  logic signed [HW-1:0] hi_q, hi_nxt;
  logic [WIDTH-1:0] lo_q, lo_nxt, div_q, rem_fix;
  logic mode_q;

  div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .zero_div_i (divisor_i == '0),
    .load_o     (load),
    .step_o     (step),
    .last_o     (last),
    .dbz_load_o (dbz_load),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .dbz_o      (div_by_zero_o)
  );

  div_step #(.WIDTH(WIDTH)) u_step (
    .mode_i (mode_q),
    .hi_i   (hi_q),
    .lo_i   (lo_q),
    .div_i  (div_q),
    .hi_o   (hi_nxt),
    .lo_o   (lo_nxt)
  );

  div_fixup #(.WIDTH(WIDTH)) u_fix (
    .mode_i (mode_q),
    .hi_i   (hi_nxt),
    .div_i  (div_q),
    .rem_o  (rem_fix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      lo_q   <= '0;
      div_q  <= '0;
      mode_q <= 1'b0;
    end else if (load) begin
      // operands enter already shifted left by one
      hi_q   <= $signed({{(WIDTH+1){1'b0}}, dividend_i[WIDTH-1]});
      lo_q   <= {dividend_i[WIDTH-2:0], 1'b0};
      div_q  <= divisor_i;
      mode_q <= mode_i;
    end else if (step) begin
      hi_q <= hi_nxt;
      lo_q <= lo_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quotient_o  <= '0;
      remainder_o <= '0;
    end else if (dbz_load) begin
      quotient_o  <= '1;
      remainder_o <= dividend_i;
    end else if (last) begin
      quotient_o  <= lo_nxt;
      remainder_o <= rem_fix;
    end
  end
endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             done_o,
  input logic             div_by_zero_o,
  input logic [WIDTH-1:0] quotient_o,
  input logic [WIDTH-1:0] remainder_o,
  input logic [WIDTH-1:0] div_q
);
  localparam int CW = $clog2(WIDTH + 2);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_cnt <= '0;
    else if (!busy_o) run_cnt <= '0;
    else run_cnt <= run_cnt + 1'b1;
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  // R4
  run_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_by_zero_o) |-> (run_cnt == CW'(WIDTH)));

  // R2
  rem_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_by_zero_o) |-> (remainder_o < div_q));

  // R5
  dbz_quot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_by_zero_o) |-> (quotient_o == '1));

  // R5
  dbz_no_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_by_zero_o) |-> !$past(busy_o));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> (done_o || ($stable(quotient_o) && $stable(remainder_o))));
endmodule

bind seq_divider seq_divider_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .div_by_zero_o (div_by_zero_o),
  .quotient_o    (quotient_o),
  .remainder_o   (remainder_o),
  .div_q         (div_q)
);

// File: tb/seq_divider_bench.sv
module seq_divider_bench;
  localparam int W = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic mode_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic busy_o, done_o, div_by_zero_o;
  logic [W-1:0] quotient_o, remainder_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  seq_divider #(.WIDTH(W)) u_seq_divider (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i), .busy_o(busy_o),
    .done_o(done_o), .div_by_zero_o(div_by_zero_o),
    .quotient_o(quotient_o), .remainder_o(remainder_o)
  );

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 200000 && !finished) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp=<200000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive start for one edge; returns at the negedge after it
  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b, input logic m);
    dividend_i = a; divisor_i = b; mode_i = m; start_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic run_div(input string req, input logic [W-1:0] a, input logic [W-1:0] b, input logic m);
    launch(a, b, m);
    chk({req, " busy"}, W'(busy_o), W'(1));
    repeat (W - 1) @(posedge clk_i);
    @(negedge clk_i);
    chk({req, " busy before end"}, W'(busy_o), W'(1));
    @(posedge clk_i); @(negedge clk_i);
    chk({req, " done"}, W'(done_o), W'(1));
    chk({req, " quot"}, quotient_o, a / b);
    chk({req, " rem"}, remainder_o, a % b);
    @(negedge clk_i);
    chk({req, " done single"}, W'(done_o), W'(0));
  endtask

  task automatic t_reset();
    chk("R1 busy", W'(busy_o), W'(0));
    chk("R1 done", W'(done_o), W'(0));
    chk("R1 dbz", W'(div_by_zero_o), W'(0));
    chk("R1 quot", quotient_o, '0);
    chk("R1 rem", remainder_o, '0);
  endtask

  task automatic t_random(input logic m);
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = $urandom >> ($urandom % 32);
      if (b == 0) b = 3;
      run_div(m ? "R3 rand" : "R2 rand", a, b, m);
    end
  endtask

  task automatic t_edges();
    for (int m = 0; m < 2; m++) begin
      run_div("R8 small", 32'd5, 32'd9, m[0]);
      run_div("R8 div1", 32'hdead_beef, 32'd1, m[0]);
      run_div("R8 max", '1, '1, m[0]);
      run_div("R8 max/2", '1, 32'd2, m[0]);
      run_div("R8 zero dividend", '0, 32'd77, m[0]);
      run_div("R8 big divisor", 32'h7fff_ffff, 32'h8000_0000, m[0]);
    end
    run_div("R3 even quot", 32'd100, 32'd7, 1'b1);
    run_div("R2 seven by two", 32'd7, 32'd2, 1'b0);
    run_div("R3 seven by two", 32'd7, 32'd2, 1'b1);
  endtask

  task automatic t_dbz();
    launch(32'h1234_5678, '0, 1'b0);
    chk("R5 done", W'(done_o), W'(1));
    chk("R5 flag", W'(div_by_zero_o), W'(1));
    chk("R5 busy", W'(busy_o), W'(0));
    chk("R5 quot", quotient_o, '1);
    chk("R5 rem", remainder_o, 32'h1234_5678);
    @(negedge clk_i);
    chk("R5 done single", W'(done_o), W'(0));
    chk("R7 flag held", W'(div_by_zero_o), W'(1));
    chk("R7 quot held", quotient_o, '1);
    launch(32'd50, 32'd6, 1'b0);
    chk("R7 flag cleared", W'(div_by_zero_o), W'(0));
    chk("R7 quot held during run", quotient_o, '1);
    repeat (W) @(posedge clk_i);
    @(negedge clk_i);
    chk("R7 new quot", quotient_o, 32'd8);
    chk("R7 new rem", remainder_o, 32'd2);
  endtask

  task automatic t_ignore();
    launch(32'd1000, 32'd33, 1'b1);
    repeat (5) @(negedge clk_i);
    dividend_i = 32'd9; divisor_i = 32'd0; mode_i = 1'b0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R6 still busy", W'(busy_o), W'(1));
    chk("R6 no dbz", W'(div_by_zero_o), W'(0));
    repeat (W - 7) @(negedge clk_i);
    chk("R6 busy on schedule", W'(busy_o), W'(1));
    @(negedge clk_i);
    chk("R6 done on schedule", W'(done_o), W'(1));
    chk("R6 quot", quotient_o, 32'd30);
    chk("R6 rem", remainder_o, 32'd10);
  endtask

  task automatic t_back_to_back();
    launch(32'd999, 32'd10, 1'b0);
    repeat (W) @(posedge clk_i);
    @(negedge clk_i);
    chk("R9 first done", W'(done_o), W'(1));
    launch(32'd12345, 32'd100, 1'b1);
    chk("R9 done dropped", W'(done_o), W'(0));
    chk("R9 new run busy", W'(busy_o), W'(1));
    chk("R7 old quot held", quotient_o, 32'd99);
    chk("R7 old rem held", remainder_o, 32'd9);
    repeat (W) @(posedge clk_i);
    @(negedge clk_i);
    chk("R9 second done", W'(done_o), W'(1));
    chk("R9 second quot", quotient_o, 32'd123);
    chk("R9 second rem", remainder_o, 32'd45);
    @(negedge clk_i);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    #1;
    t_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_edges();
    t_random(1'b0);
    t_random(1'b1);
    t_dbz();
    t_ignore();
    t_back_to_back();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule